// File: doc/BRIEF.md
# Real-Time Data Link Burst Framer

This block sends the machine-parameter burst that precedes each machine cycle. A one-cycle start pulse begins a burst. The framer walks the parameter slots in ascending index order and sends only the slots whose bit is set in an enable mask. For each slot it sends a 40-bit frame on a single serial line. To get the frame's payload, it drives a read address into an external register file, and the register file answers with the 24-bit parameter word in the same cycle.

Every frame carries three fields, sent most significant bit first: the frame's own number, then the payload, then an 8-bit check code over the first two fields. After the last enabled slot, the framer sends a closing frame numbered 255. The payload of that frame is a 24-bit check code accumulated over the payloads of every parameter frame in the burst.

Bits go out at a fixed rate of one bit every `BIT_DIV` system clocks, which gives a 10 MHz line from a 100 MHz clock. Frames follow each other with no gap. A busy flag covers the whole burst.

Top module: `rtdl_framer`

## Requirements
- R1: Each frame is 40 bits sent most significant bit first. Bits 39..32 hold the frame number, bits 31..8 hold the 24-bit payload and bits 7..0 hold the frame check byte. A parameter frame's number equals its slot index.
- R2: The frame check byte is a CRC with polynomial x^8+x^2+x+1 (0x07) and initial value 0x00. It is computed bit-serially, most significant bit first, over the 32 bits formed by the number and the payload.
- R3: Only slots whose bit is set in `frame_mask` are sent, in ascending index order. The payload of each frame is the `param_data` value returned while `param_addr` equals that slot's index.
- R4: Every burst ends with exactly one frame numbered 0xFF. Its payload is a CRC-24 with polynomial 0x864CFB and initial value 0xB704CE, computed MSB first over the payloads of the burst's parameter frames in the order they were sent. With an all-zero mask, only this frame is sent, and its payload is 0xB704CE.
- R5: Each bit is held on `ser_out` for `BIT_DIV` clocks. `bit_en` is high for one clock at the start of each bit. `frame_start` is high only together with the first bit of a frame. Frames follow each other with no idle bit periods between them.
- R6: A start pulse seen while idle raises `busy` on the next clock, and the first bit of the first frame appears in that same clock. `busy` stays high for exactly (frames sent) × 40 × `BIT_DIV` clocks and falls right after the last bit period of frame 0xFF.
- R7: A start pulse that arrives while `busy` is high is ignored. The burst in progress goes on unchanged.
- R8: The enable mask is captured when the start is accepted. Changes to `frame_mask` during a burst have no effect on that burst.
- R9: During reset, `busy`, `ser_out`, `bit_en` and `frame_start` are low.
- R10: While idle, `ser_out`, `bit_en` and `frame_start` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that requests a burst |
| frame_mask | input | NUM_FRAMES | Enable bit per parameter slot |
| param_addr | output | $clog2(NUM_FRAMES) | Read index into the parameter register file |
| param_data | input | 24 | Parameter word at `param_addr`, returned in the same cycle |
| ser_out | output | 1 | Serial line, MSB first |
| bit_en | output | 1 | High on the first clock of each bit period |
| frame_start | output | 1 | High on the first bit of each frame |
| busy | output | 1 | High for the length of a burst |

## Verification
The start pulse is driven on one falling edge and taken on the rising edge that follows. On the next falling edge the bench expects `busy`, `bit_en` and `frame_start` all to be high. After that, it captures a bit only on falling edges where `bit_en` is high, so frame contents are compared without any fixed latency assumption. Separately, the bench checks that consecutive bits are exactly `BIT_DIV` clocks apart and that the burst keeps `busy` high for frames × 40 × `BIT_DIV` falling edges. Idle outputs are checked two clocks after `busy` falls. Pokes at the start and mask inputs land 30 clocks into a burst, well inside even the shortest burst.

// File: rtl/rtdl_pkg.sv
package rtdl_pkg;

  localparam int FRAME_W = 40;
  localparam int NUM_W   = 8;
  localparam int DATA_W  = 24;

  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [23:0] CRC24_POLY = 24'h864CFB;
  localparam logic [23:0] CRC24_SEED = 24'hB704CE;
  localparam logic [7:0]  CLOSE_NUM  = 8'hFF;

  // Per-frame check byte over number and payload, MSB first, seed zero.
  function automatic logic [7:0] crc8_head(input logic [31:0] msg);
    logic [7:0] c;
    c = '0;
    for (int i = 31; i >= 0; i--) begin
      if (c[7] ^ msg[i]) c = (c << 1) ^ CRC8_POLY;
      else               c = c << 1;
    end
    return c;
  endfunction

  // Fold one 24-bit payload into the running burst code, MSB first.
  function automatic logic [23:0] crc24_fold(input logic [23:0] acc,
                                             input logic [23:0] word);
    logic [23:0] c;
    c = acc;
    for (int i = 23; i >= 0; i--) begin
      if (c[23] ^ word[i]) c = (c << 1) ^ CRC24_POLY;
      else                 c = c << 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rtdl_slot_pick.sv
// Lowest enabled slot index at or above a starting point.
module rtdl_slot_pick #(
  parameter int NUM_FRAMES = 128,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic [NUM_FRAMES-1:0] mask,
  input  logic [IDX_W:0]        from_idx,
  output logic                  hit,
  output logic [IDX_W-1:0]      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from_idx))) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rtdl_frame_pack.sv
// Assembles the 40-bit frame: number, payload, check byte.
module rtdl_frame_pack
  import rtdl_pkg::*;
(
  input  logic [NUM_W-1:0]   num,
  input  logic [DATA_W-1:0]  payload,
  output logic [FRAME_W-1:0] frame
);
  logic [7:0] chk;
  always_comb begin
    chk   = crc8_head({num, payload});
    frame = {num, payload, chk};
  end
endmodule

// File: rtl/rtdl_shifter.sv
// Holds each bit BIT_DIV clocks and shifts the frame out MSB first.
module rtdl_shifter
  import rtdl_pkg::*;
#(
  parameter int BIT_DIV = 10,
  localparam int DIV_W = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1,
  localparam int BC_W  = $clog2(FRAME_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               ser_out,
  output logic               bit_en,
  output logic               frame_start,
  output logic               last_tick
);
  logic [FRAME_W-1:0] sh_q;
  logic [DIV_W-1:0]   div_q;
  logic [BC_W-1:0]    bc_q;
  logic               act_q;
  logic               div_end;
  logic               bit_last;

  assign div_end  = (div_q == DIV_W'(BIT_DIV - 1));
  assign bit_last = (bc_q == BC_W'(FRAME_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      div_q <= '0;
      bc_q  <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      sh_q  <= frame_in;
      div_q <= '0;
      bc_q  <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (div_end) begin
        div_q <= '0;
        if (bit_last) begin
          act_q <= 1'b0;
        end else begin
          bc_q <= bc_q + 1'b1;
          sh_q <= sh_q << 1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign ser_out     = act_q & sh_q[FRAME_W-1];
  assign bit_en      = act_q & (div_q == '0);
  assign frame_start = bit_en & (bc_q == '0);
  assign last_tick   = act_q & div_end & bit_last;
endmodule

// File: rtl/rtdl_framer.sv
module rtdl_framer
  import rtdl_pkg::*;
#(
  parameter int NUM_FRAMES = 128,
  parameter int BIT_DIV    = 10,
  localparam int IDX_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NUM_FRAMES-1:0] frame_mask,
  output logic [IDX_W-1:0]      param_addr,
  input  logic [DATA_W-1:0]     param_data,
  output logic                  ser_out,
  output logic                  bit_en,
  output logic                  frame_start,
  output logic                  busy
);
  logic                  busy_q;
  logic                  final_q;
  logic [IDX_W-1:0]      cur_q;
  logic [NUM_FRAMES-1:0] mask_q;
  logic [DATA_W-1:0]     crc_q;

  logic                  idle;
  logic [NUM_FRAMES-1:0] mask_src;
  logic [IDX_W:0]        from_idx;
  logic                  sel_hit;
  logic [IDX_W-1:0]      sel_idx;
  logic                  start_ok;
  logic                  last_tick;
  logic                  load;
  logic                  next_close;
  logic [DATA_W-1:0]     crc_base;
  logic [NUM_W-1:0]      fr_num;
  logic [DATA_W-1:0]     fr_data;
  logic [FRAME_W-1:0]    fr_bits;

  assign idle     = ~busy_q;
  assign mask_src = idle ? frame_mask : mask_q;
  assign from_idx = idle ? '0 : ({1'b0, cur_q} + 1'b1);

  rtdl_slot_pick #(.NUM_FRAMES(NUM_FRAMES)) u_pick (
    .mask     (mask_src),
    .from_idx (from_idx),
    .hit      (sel_hit),
    .idx      (sel_idx)
  );

  assign param_addr = sel_idx;
  assign start_ok   = idle & start;
  assign load       = start_ok | (last_tick & ~final_q);
  assign next_close = ~sel_hit;
  assign crc_base   = idle ? CRC24_SEED : crc_q;
  assign fr_num     = next_close ? CLOSE_NUM : NUM_W'(sel_idx);
  assign fr_data    = next_close ? crc_base : param_data;

  rtdl_frame_pack u_pack (
    .num     (fr_num),
    .payload (fr_data),
    .frame   (fr_bits)
  );

  rtdl_shifter #(.BIT_DIV(BIT_DIV)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (load),
    .frame_in    (fr_bits),
    .ser_out     (ser_out),
    .bit_en      (bit_en),
    .frame_start (frame_start),
    .last_tick   (last_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      final_q <= 1'b0;
      cur_q   <= '0;
      mask_q  <= '0;
      crc_q   <= CRC24_SEED;
    end else begin
      if (start_ok) begin
        busy_q <= 1'b1;
        mask_q <= frame_mask;
      end else if (last_tick & final_q) begin
        busy_q <= 1'b0;
      end
      if (load) begin
        cur_q   <= sel_idx;
        final_q <= next_close;
        if (!next_close) crc_q <= crc24_fold(crc_base, param_data);
      end
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/rtdl_framer_chk.sv
module rtdl_framer_chk #(
  parameter int BIT_DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic ser_out,
  input logic bit_en,
  input logic frame_start,
  input logic load,
  input logic last_tick,
  input logic final_q
);
  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_first_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> frame_start);

  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(last_tick && final_q));

  assert_fs_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_en);

  generate
    if (BIT_DIV > 1) begin : g_gap
      assert_bit_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> !bit_en);
    end
  endgenerate

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_out && !bit_en && !frame_start));

  assert_no_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy || last_tick));
endmodule

bind rtdl_framer rtdl_framer_chk #(.BIT_DIV(BIT_DIV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .ser_out     (ser_out),
  .bit_en      (bit_en),
  .frame_start (frame_start),
  .load        (load),
  .last_tick   (last_tick),
  .final_q     (final_q)
);

// File: tb/rtdl_framer_tb.sv
module rtdl_framer_tb;
  localparam int NF = 8;
  localparam int BD = 2;
  localparam int AW = $clog2(NF);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NF-1:0] frame_mask = '0;
  logic [AW-1:0] param_addr;
  logic [23:0]   param_data;
  logic          ser_out, bit_en, frame_start, busy;
  logic [23:0]   seed = '0;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  function automatic logic [23:0] pword(input int a, input logic [23:0] s);
    logic [23:0] v;
    v = 24'(a * 24'h0A3C5B) + 24'(s * 24'h1357);
    return v ^ 24'h5A5A5A;
  endfunction

  assign param_data = pword(int'(param_addr), seed);

  rtdl_framer #(.NUM_FRAMES(NF), .BIT_DIV(BD)) u_dut (
    .clk, .rst_n, .start, .frame_mask, .param_addr, .param_data,
    .ser_out, .bit_en, .frame_start, .busy
  );

  // Long-division remainder form: message followed by eight zero bits.
  function automatic logic [7:0] ref_crc8(input logic [31:0] m);
    logic [39:0] aug;
    logic [7:0]  r;
    logic        top;
    aug = {m, 8'h00};
    r = '0;
    for (int i = 39; i >= 0; i--) begin
      top = r[7];
      r = {r[6:0], aug[i]};
      if (top) r = r ^ 8'h07;
    end
    return r;
  endfunction

  function automatic logic [23:0] ref_crc24(input logic [23:0] acc, input logic [23:0] w);
    int r;
    r = int'(acc);
    for (int i = 23; i >= 0; i--) begin
      r = r ^ (int'(w[i]) << 23);
      r = r << 1;
      if (r[24]) r = r ^ 32'h1864CFB;
    end
    return r[23:0];
  endfunction

  function automatic logic [39:0] mkframe(input logic [7:0] n, input logic [23:0] d);
    return {n, d, ref_crc8({n, d})};
  endfunction

  logic [39:0] rx [16];
  logic [39:0] rx_sh = '0;
  int rx_n = 0, bitpos = 0, fs_err = 0, tim_err = 0, busy_cnt = 0;
  int cyc = 0, prev_cyc = 0;
  bit have_prev = 0;

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_cnt++;
    if (rst_n && bit_en) begin
      if (frame_start != (bitpos == 0)) fs_err++;
      if (have_prev && (cyc - prev_cyc != BD)) tim_err++;
      prev_cyc = cyc;
      have_prev = 1;
      rx_sh = {rx_sh[38:0], ser_out};
      bitpos++;
      if (bitpos == 40) begin
        if (rx_n < 16) rx[rx_n] = rx_sh;
        rx_n++;
        bitpos = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_burst(input logic [NF-1:0] m, input logic [23:0] sd, input bit poke);
    logic [39:0] ex [16];
    int en_n;
    logic [23:0] acc;
    int n;
    int bad;
    en_n = 0;
    acc = 24'hB704CE;
    for (int i = 0; i < NF; i++) begin
      if (m[i]) begin
        ex[en_n] = mkframe(8'(i), pword(i, sd));
        acc = ref_crc24(acc, pword(i, sd));
        en_n++;
      end
    end
    ex[en_n] = mkframe(8'hFF, acc);
    en_n++;
    seed = sd;
    frame_mask = m;
    @(posedge clk);
    rx_n = 0; bitpos = 0; fs_err = 0; tim_err = 0; busy_cnt = 0; have_prev = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy && bit_en && frame_start, "R6", "busy/first bit one clock after start",
          {busy, bit_en, frame_start}, 3'b111);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 30) begin start = 1'b1; frame_mask = ~m; end
      if (poke && n == 31) start = 1'b0;
    end
    check(busy_cnt == en_n * 40 * BD, "R6", "busy length", busy_cnt, en_n * 40 * BD);
    check(rx_n == en_n, poke ? "R7 R8" : "R3", "frame count", rx_n, en_n);
    bad = -1;
    for (int i = 0; i < en_n && i < 16; i++)
      if (bad < 0 && rx[i] !== ex[i]) bad = i;
    if (bad >= 0)
      check(1'b0, "R1 R2 R3 R4", "frame contents", rx[bad], ex[bad]);
    else
      check(1'b1, "R1 R2 R3 R4", "frame contents", 0, 0);
    check(fs_err == 0 && tim_err == 0, "R5", "bit spacing/frame_start errors",
          fs_err + tim_err, 0);
    frame_mask = m;
    repeat (2) @(negedge clk);
    check(!ser_out && !bit_en && !frame_start && !busy, "R10", "idle outputs",
          {busy, ser_out, bit_en, frame_start}, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !ser_out && !bit_en && !frame_start, "R9", "reset outputs",
          {busy, ser_out, bit_en, frame_start}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R4: every mask pattern of the small configuration, empty mask included.
    for (int m = 0; m < (1 << NF); m++)
      run_burst(NF'(m), 24'(m * 24'h111 + 3), 1'b0);
    // R7 R8: start pulse and mask change in the middle of a burst.
    run_burst(8'hA5, 24'h00C0DE, 1'b1);
    run_burst(8'h00, 24'h000777, 1'b1);
    run_burst(8'hFF, 24'h123456, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule